// File: doc/BRIEF.md
# Physical Address Region Router

This block classifies each 40-bit physical address issued by a core and names the place the request must go. The address space is split by its upper bits into five regions:
- a per-tile device window;
- DRAM reached through the cached L2 path;
- DRAM reached uncached;
- a window for streaming accelerators;
- everything above, which leaves the chip.

For the device window the router also splits the address into tile, device and byte offset fields.

Two system shapes are supported, selected by an input. In the single-core shape, off-chip addresses and device-window addresses naming a foreign tile are handed to the I/O port. In the multi-core shape, an off-chip address carries a 6-bit domain number in its top bits. That number is compared with this chip's own domain number to choose an east or west hop, or local delivery. Addresses that fall in a configurable host range are steered by the host's domain number instead. Domain bits that the configured mask does not enable raise an access fault. The decision is registered once by default, giving one cycle of latency; a parameter removes the register.

Top module: `addr_region_router`

## Requirements
- R1: Regions are decoded from the address: below 0x00_8000_0000 is the device window (dest 1), up to 0x00_FFFF_FFFF is cached DRAM (dest 2), 0x01_0000_0000 to 0x01_FFFF_FFFF is uncached DRAM (dest 3), 0x02_0000_0000 to 0x03_FFFF_FFFF is the accelerator window (dest 4), and 0x04_0000_0000 upward is off-chip.
- R2: For dest 1 the outputs give offset = address[19:0], device = address[23:20], tile = address[30:24]; for every other dest these three outputs are zero.
- R3: In single-core mode (multicore_i=0), a device-window address whose tile field differs from my_tile_i goes to I/O (dest 5) with direction 0 (none).
- R4: In single-core mode every off-chip address goes to I/O (dest 5) with direction 0.
- R5: In multi-core mode an off-chip address gets dest 6 and a direction from its target domain T versus my_did_i: T greater gives east (2), T smaller gives west (3), T equal gives local (1). Without the host override, T is address[39:34].
- R6: A target domain of 0 always yields direction local (1), whatever my_did_i holds.
- R7: In multi-core mode, an off-chip address with host_base_i <= address <= host_last_i uses host_did_i as its target domain.
- R8: rsp_fault_o is 1 exactly when address[39:34] has a bit set whose bit in hio_mask_i is 0.
- R9: With the output register present, a request presented in one cycle appears on the outputs after the next rising clock edge. rsp_valid_o follows req_valid_i with that delay and is 0 during and after reset until a request arrives.
- R10: In multi-core mode every device-window address gets dest 1 with its own tile field, whether or not that field matches my_tile_i.
- R11: When rsp_valid_o is 0, all other outputs are 0 (dest 0, direction 0, no fault, zero fields).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| multicore_i | input | 1 | 1 selects multi-core routing, 0 single-core |
| my_tile_i | input | 7 | This tile's index |
| my_did_i | input | 6 | This chip's domain number |
| host_did_i | input | 6 | Domain number toward the host |
| hio_mask_i | input | 6 | Enabled domain bits; a set address bit outside it faults |
| host_base_i | input | 40 | First address of host space |
| host_last_i | input | 40 | Last address of host space (inclusive) |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 40 | Physical address |
| rsp_valid_o | output | 1 | Decision present |
| rsp_dest_o | output | 3 | 0 none, 1 device, 2 cached DRAM, 3 uncached DRAM, 4 accelerator, 5 I/O, 6 network |
| rsp_dir_o | output | 2 | 0 none, 1 local, 2 east, 3 west |
| rsp_fault_o | output | 1 | Access fault on masked domain bits |
| rsp_tile_o | output | 7 | Tile field of a device-window address |
| rsp_dev_o | output | 4 | Device field |
| rsp_off_o | output | 20 | Byte offset within the device |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid pipeline;
- that idle outputs are zero;
- that fields are zero outside the device window;
- that a direction appears only together with the network destination;
- that single-core decisions never carry a direction and keep the local tile;
- that a fault only ever accompanies an off-chip destination.

Which region an address lands in, the east/west choice against the chip's domain number, the host-range override, and the exact fault condition are only shown by the bench. It uses directed boundary addresses at each region edge plus seeded random addresses across all regions and both modes, and compares every output with its own model.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;

    typedef enum logic [2:0] {
        DEST_NONE   = 3'd0,
        DEST_DEVICE = 3'd1,
        DEST_L2     = 3'd2,
        DEST_UCDRAM = 3'd3,
        DEST_ACCEL  = 3'd4,
        DEST_IO     = 3'd5,
        DEST_NET    = 3'd6
    } dest_e;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_LOCAL = 2'd1,
        DIR_EAST  = 2'd2,
        DIR_WEST  = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        RGN_WINDOW  = 3'd0,
        RGN_CACHED  = 3'd1,
        RGN_UNCACHE = 3'd2,
        RGN_ACCEL   = 3'd3,
        RGN_OFFCHIP = 3'd4
    } region_e;

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
    import addr_router_pkg::*;
#(
    parameter int PADDR_W = 40,
    parameter int TILE_W  = 7,
    parameter int DEV_W   = 4,
    parameter int OFF_W   = 20
) (
    input  logic [PADDR_W-1:0] addr_i,
    output region_e            region_o,
    output logic [TILE_W-1:0]  tile_o,
    output logic [DEV_W-1:0]   dev_o,
    output logic [OFF_W-1:0]   off_o
);
    // Window spans TILE+DEV+OFF bits; the next three bits select the DRAM
    // and accelerator regions, everything above is off-chip.
    localparam int WIN_W      = TILE_W + DEV_W + OFF_W;
    localparam int CACHED_BIT = WIN_W;
    localparam int UC_BIT     = WIN_W + 1;
    localparam int ACCEL_BIT  = WIN_W + 2;
    localparam int OFF_LSB    = WIN_W + 3;

    always_comb begin
        if (|addr_i[PADDR_W-1:OFF_LSB])  region_o = RGN_OFFCHIP;
        else if (addr_i[ACCEL_BIT])      region_o = RGN_ACCEL;
        else if (addr_i[UC_BIT])         region_o = RGN_UNCACHE;
        else if (addr_i[CACHED_BIT])     region_o = RGN_CACHED;
        else                             region_o = RGN_WINDOW;
    end

    assign off_o  = addr_i[OFF_W-1:0];
    assign dev_o  = addr_i[OFF_W+DEV_W-1:OFF_W];
    assign tile_o = addr_i[WIN_W-1:OFF_W+DEV_W];

endmodule

// File: rtl/addr_domain_route.sv
module addr_domain_route
    import addr_router_pkg::*;
#(
    parameter int DID_W = 6
) (
    input  logic [DID_W-1:0] target_did_i,
    input  logic [DID_W-1:0] my_did_i,
    output dir_e             dir_o
);
    // Domain 0 is reserved for the local chip; otherwise only relative order counts.
    always_comb begin
        if (target_did_i == '0 || target_did_i == my_did_i) dir_o = DIR_LOCAL;
        else if (target_did_i > my_did_i)                   dir_o = DIR_EAST;
        else                                                dir_o = DIR_WEST;
    end

endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
    import addr_router_pkg::*;
#(
    parameter int PADDR_W = 40,
    parameter int TILE_W  = 7,
    parameter int DEV_W   = 4,
    parameter int OFF_W   = 20,
    parameter int DID_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               multicore_i,
    input  logic [TILE_W-1:0]  my_tile_i,
    input  logic [DID_W-1:0]   my_did_i,
    input  logic [DID_W-1:0]   host_did_i,
    input  logic [DID_W-1:0]   hio_mask_i,
    input  logic [PADDR_W-1:0] host_base_i,
    input  logic [PADDR_W-1:0] host_last_i,
    input  logic               req_valid_i,
    input  logic [PADDR_W-1:0] req_addr_i,
    output logic               rsp_valid_o,
    output logic [2:0]         rsp_dest_o,
    output logic [1:0]         rsp_dir_o,
    output logic               rsp_fault_o,
    output logic [TILE_W-1:0]  rsp_tile_o,
    output logic [DEV_W-1:0]   rsp_dev_o,
    output logic [OFF_W-1:0]   rsp_off_o
);
    localparam int DID_LSB = PADDR_W - DID_W;

    typedef struct packed {
        logic              valid;
        dest_e             dest;
        dir_e              dir;
        logic              fault;
        logic [TILE_W-1:0] tile;
        logic [DEV_W-1:0]  dev;
        logic [OFF_W-1:0]  off;
    } decision_t;

    region_e           region;
    logic [TILE_W-1:0] f_tile;
    logic [DEV_W-1:0]  f_dev;
    logic [OFF_W-1:0]  f_off;
    logic [DID_W-1:0]  addr_did;
    logic [DID_W-1:0]  target_did;
    logic              in_host;
    dir_e              net_dir;
    decision_t         dec_d;
    decision_t         dec_q;

    addr_region_decode #(
        .PADDR_W (PADDR_W),
        .TILE_W  (TILE_W),
        .DEV_W   (DEV_W),
        .OFF_W   (OFF_W)
    ) u_decode (
        .addr_i   (req_addr_i),
        .region_o (region),
        .tile_o   (f_tile),
        .dev_o    (f_dev),
        .off_o    (f_off)
    );

    assign addr_did   = req_addr_i[PADDR_W-1:DID_LSB];
    assign in_host    = (req_addr_i >= host_base_i) && (req_addr_i <= host_last_i);
    assign target_did = in_host ? host_did_i : addr_did;

    addr_domain_route #(
        .DID_W (DID_W)
    ) u_route (
        .target_did_i (target_did),
        .my_did_i     (my_did_i),
        .dir_o        (net_dir)
    );

    always_comb begin
        dec_d = '0;
        if (req_valid_i) begin
            dec_d.valid = 1'b1;
            dec_d.fault = |(addr_did & ~hio_mask_i);
            unique case (region)
                RGN_WINDOW: begin
                    if (!multicore_i && (f_tile != my_tile_i)) begin
                        dec_d.dest = DEST_IO;
                    end else begin
                        dec_d.dest = DEST_DEVICE;
                        dec_d.tile = f_tile;
                        dec_d.dev  = f_dev;
                        dec_d.off  = f_off;
                    end
                end
                RGN_CACHED:  dec_d.dest = DEST_L2;
                RGN_UNCACHE: dec_d.dest = DEST_UCDRAM;
                RGN_ACCEL:   dec_d.dest = DEST_ACCEL;
                default: begin
                    if (multicore_i) begin
                        dec_d.dest = DEST_NET;
                        dec_d.dir  = net_dir;
                    end else begin
                        dec_d.dest = DEST_IO;
                    end
                end
            endcase
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dec_q <= '0;
                else        dec_q <= dec_d;
            end

            // R9: one-cycle valid pipeline
            a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                $past(req_valid_i) == rsp_valid_o);

            // R3: single-core device decisions keep this tile
            a_r3_own_tile_only: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid_o && !$past(multicore_i) && rsp_dest_o == DEST_DEVICE)
                |-> rsp_tile_o == $past(my_tile_i));

            // R4: single-core decisions never carry a direction
            a_r4_uni_no_dir: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid_o && !$past(multicore_i)) |-> rsp_dir_o == DIR_NONE);
        end else begin : g_comb
            assign dec_q = dec_d;
        end
    endgenerate

    assign rsp_valid_o = dec_q.valid;
    assign rsp_dest_o  = dec_q.dest;
    assign rsp_dir_o   = dec_q.dir;
    assign rsp_fault_o = dec_q.fault;
    assign rsp_tile_o  = dec_q.tile;
    assign rsp_dev_o   = dec_q.dev;
    assign rsp_off_o   = dec_q.off;

    // R11: idle outputs are all zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> (rsp_dest_o == DEST_NONE && rsp_dir_o == DIR_NONE && !rsp_fault_o
                          && rsp_tile_o == '0 && rsp_dev_o == '0 && rsp_off_o == '0));

    // R2: fields only for the device window
    a_r2_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_dest_o != DEST_DEVICE)
        |-> (rsp_tile_o == '0 && rsp_dev_o == '0 && rsp_off_o == '0));

    // R5: a direction appears exactly with the network destination
    a_r5_dir_with_net: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ((rsp_dir_o != DIR_NONE) == (rsp_dest_o == DEST_NET)));

    // R8: a fault only on off-chip destinations
    a_r8_fault_offchip: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o) |-> (rsp_dest_o == DEST_IO || rsp_dest_o == DEST_NET));

endmodule

// File: tb/tb_addr_region_router.sv
`timescale 1ns/1ps
module tb_addr_region_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        multicore_i = 1'b0;
    logic [6:0]  my_tile_i = '0;
    logic [5:0]  my_did_i = '0;
    logic [5:0]  host_did_i = '0;
    logic [5:0]  hio_mask_i = '1;
    logic [39:0] host_base_i = '1;
    logic [39:0] host_last_i = '0;
    logic        req_valid_i = 1'b0;
    logic [39:0] req_addr_i = '0;
    logic        rsp_valid_o;
    logic [2:0]  rsp_dest_o;
    logic [1:0]  rsp_dir_o;
    logic        rsp_fault_o;
    logic [6:0]  rsp_tile_o;
    logic [3:0]  rsp_dev_o;
    logic [19:0] rsp_off_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    addr_region_router dut (
        .clk(clk), .rst_n(rst_n), .multicore_i(multicore_i), .my_tile_i(my_tile_i),
        .my_did_i(my_did_i), .host_did_i(host_did_i), .hio_mask_i(hio_mask_i),
        .host_base_i(host_base_i), .host_last_i(host_last_i), .req_valid_i(req_valid_i),
        .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o), .rsp_dest_o(rsp_dest_o),
        .rsp_dir_o(rsp_dir_o), .rsp_fault_o(rsp_fault_o), .rsp_tile_o(rsp_tile_o),
        .rsp_dev_o(rsp_dev_o), .rsp_off_o(rsp_off_o)
    );

    // {valid, dest, dir, fault, tile, dev, off}
    function automatic logic [37:0] model(input logic v, input logic [39:0] a);
        logic [2:0] d; logic [1:0] r; logic f; logic [30:0] fld; logic [5:0] tgt;
        d = 3'd0; r = 2'd0; f = 1'b0; fld = '0;
        if (!v) return '0;
        f = |(a[39:34] & ~hio_mask_i);
        if (a[39:34] != 6'd0) begin
            if (!multicore_i) d = 3'd5;
            else begin
                d = 3'd6;
                tgt = (a >= host_base_i && a <= host_last_i) ? host_did_i : a[39:34];
                if (tgt == 6'd0 || tgt == my_did_i) r = 2'd1;
                else if (tgt > my_did_i)            r = 2'd2;
                else                                r = 2'd3;
            end
        end else if (a[33]) d = 3'd4;
        else if (a[32])     d = 3'd3;
        else if (a[31])     d = 3'd2;
        else if (!multicore_i && a[30:24] != my_tile_i) d = 3'd5;
        else begin d = 3'd1; fld = a[30:0]; end
        return {1'b1, d, r, f, fld};
    endfunction

    task automatic check(input string tag);
        logic [37:0] exp, act;
        exp = model(req_valid_i, req_addr_i);
        act = {rsp_valid_o, rsp_dest_o, rsp_dir_o, rsp_fault_o, rsp_tile_o, rsp_dev_o, rsp_off_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, req_addr_i, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [39:0] a, input string tag);
        @(negedge clk);
        req_valid_i = v;
        req_addr_i  = a;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({rsp_valid_o, rsp_dest_o, rsp_fault_o} !== 5'b0) begin
            failures++;
            $display("FAIL R9 reset actual=%b expected=0", {rsp_valid_o, rsp_dest_o, rsp_fault_o});
        end
        rst_n = 1'b1;

        // R1 R2 boundaries, single-core
        my_tile_i = 7'h7F;
        apply(1'b1, 40'h00_7FFF_FFFF, "R1 R2 window top");
        my_tile_i = 7'h04;
        apply(1'b1, 40'h00_0420_0002, "R2 field split");
        apply(1'b1, 40'h00_8000_0000, "R1 cached low");
        apply(1'b1, 40'h00_FFFF_FFFF, "R1 cached high");
        apply(1'b1, 40'h01_0000_0000, "R1 uncached low");
        apply(1'b1, 40'h03_FFFF_FFFF, "R1 accel high");
        apply(1'b1, 40'h02_0000_0000, "R1 accel low");
        my_tile_i = 7'h00;
        apply(1'b1, 40'h00_0420_0002, "R3 foreign tile");
        apply(1'b1, 40'h04_0000_0000, "R4 offchip low");
        apply(1'b1, 40'h3F_0000_0000, "R4 offchip uni");
        // R10 multi-core window
        multicore_i = 1'b1;
        apply(1'b1, 40'h00_0420_0002, "R10 any tile");
        // R5 direction
        my_did_i = 6'd5;
        apply(1'b1, {6'd7, 34'h1234}, "R5 east");
        apply(1'b1, {6'd3, 34'h1234}, "R5 west");
        apply(1'b1, {6'd5, 34'h1234}, "R5 equal");
        // R7 host override, R6 domain zero
        host_base_i = {6'd7, 34'h0};
        host_last_i = {6'd7, 34'hFFFF};
        host_did_i  = 6'd2;
        apply(1'b1, {6'd7, 34'h1234}, "R7 host west");
        apply(1'b1, {6'd7, 34'h10000}, "R7 outside host");
        host_did_i  = 6'd0;
        apply(1'b1, {6'd7, 34'h0}, "R6 host domain zero");
        // R8 fault
        hio_mask_i = 6'h0F;
        apply(1'b1, {6'h10, 34'h5}, "R8 masked bit");
        apply(1'b1, {6'h0F, 34'h5}, "R8 enabled bits");
        // R11 idle, R9 pipeline
        apply(1'b0, {6'h10, 34'h5}, "R11 idle zero");
        apply(1'b1, 40'h00_8000_0000, "R9 valid again");
        apply(1'b0, 40'h00_0000_0000, "R9 R11 drop");

        // random mix
        begin
            int unsigned seed = 32'd17;
            void'($urandom(seed));
        end
        for (int i = 0; i < 3000; i++) begin
            logic [39:0] a;
            int unsigned k;
            k = $urandom_range(0, 5);
            a = {$urandom, $urandom};
            case (k)
                0: a[39:31] = '0;
                1: begin a[39:32] = '0; a[31] = 1'b1; end
                2: begin a[39:33] = '0; a[32] = 1'b1; end
                3: begin a[39:34] = '0; a[33] = 1'b1; end
                default: if (a[39:34] == '0) a[34] = 1'b1;
            endcase
            multicore_i = $urandom_range(0, 1);
            my_tile_i   = (k == 0 && $urandom_range(0, 1)) ? a[30:24] : 7'($urandom);
            my_did_i    = 6'($urandom);
            host_did_i  = ($urandom_range(0, 7) == 0) ? 6'd0 : 6'($urandom);
            hio_mask_i  = $urandom_range(0, 1) ? 6'h3F : 6'($urandom);
            host_base_i = {6'($urandom), 34'h0};
            host_last_i = host_base_i + 40'h8_0000_0000;
            apply($urandom_range(0, 9) != 0, a, "R1 R5 R7 R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule